// File: doc/BRIEF.md
# Clock Generator Configuration Serial Slave

This block is the serial configuration port of a system clock generator. It listens on a two-wire I2C bus as a slave. It accepts a block-write that fills a six-byte configuration image, and it answers a block-read that returns that image. The bus clock and data lines are sampled on the chip's own fast clock through two-flop synchronizers. The slave never drives the data line high. It only pulls it low, through an output-enable.

A write starts with the write address. Two header bytes follow, a command code and a byte count. Both are acknowledged and both are thrown away. The data bytes after them land in configuration byte 0, then byte 1, and so on upward, until the master ends with a STOP. A read starts with the read address. The slave answers with a count of six and then sends bytes 0 to 5. Some bits of the image are fixed: a version bit, reserved ones, and the inverted levels of three latched strap inputs. The full image is presented in parallel to the clock control logic.

Top module: `clkcfg_serial_slave`

## Requirements
- R1: The 8-bit address 0xD2 (write) and 0xD3 (read) are acknowledged by pulling SDA low in the ninth clock. Any other address gets no acknowledge, and the slave stays silent until the next START.
- R2: On a write, the two bytes after the address are acknowledged and discarded. The following data bytes are stored into bytes 0, 1, 2, and so on, in that order, and each is acknowledged.
- R3: A write may end with STOP after any whole byte; bytes not reached keep their values. Data bytes beyond byte 5 are acknowledged but stored nowhere.
- R4: A byte cut short by a STOP or a repeated START is not stored. A START always restarts address reception.
- R5: On a read, the slave sends the count value 6, then image bytes 0 to 5, each MSB first, while the master acknowledges.
- R6: After reset, byte 0 is 0x00 and every writable bit of bytes 1 to 5 is 1.
- R7: Writable bits are: all of byte 0; byte 1 bits 3:0; byte 2 bits 6:0; all of byte 3; byte 4 bits 3:0; byte 5 bits 4, 1, 0. All other bits are read-only. Byte 1 bit 7 is the VERSION parameter (default 0). Byte 2 bit 7 is NOT fs[1]. Byte 4 bit 7 is NOT fs[0]. Byte 5 bit 7 is NOT fs[2]. Every other read-only bit reads 1.
- R8: cfg_o carries image byte k at bits [8k+7:8k]. It shows a stored byte before the STOP that ends the write.
- R9: When the master does not acknowledge a read byte, the slave releases SDA and sends nothing more until the next START. A STOP always leaves SDA released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock, much faster than SCL |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Serial bus clock line |
| sda_i | input | 1 | Serial bus data line as seen on the wire |
| strap_fs | input | 3 | Latched frequency-select strap levels |
| sda_oe | output | 1 | 1 pulls the data line low |
| cfg_o | output | 48 | Configuration image, byte k at [8k+7:8k] |

## Verification
A table of write patterns is sent in turn, and each is followed by a block-read: all zeros, all ones, alternating bit patterns, and a two-byte partial write. The zeros and ones patterns show each bit as writable or fixed. The alternating patterns expose swapped bytes or a shifted byte order. The partial write shows that bytes not reached keep their values. Directed sequences then try a foreign address, a run past byte 5, a STOP and a repeated START in mid-byte, a change of strap levels, and an early master NACK. Together these separate header discard, overrun, abort handling and read termination.

// File: rtl/clkcfg_pkg.sv
package clkcfg_pkg;

    localparam int NREG = 6;
    localparam int IDXW = 4;
    localparam int CNTW = 4;

    typedef enum logic [2:0] {
        S_IDLE,
        S_RX,
        S_ACK1,
        S_ACK2,
        S_TX,
        S_TXACK
    } bus_state_e;

    typedef struct packed {
        bus_state_e      state;
        logic [CNTW-1:0] cnt;
        logic [7:0]      sh;
        logic [IDXW-1:0] idx;
        logic            rd;
        logic            addr_ph;
        logic            oe;
        logic            mack;
    } eng_t;

    function automatic logic [7:0] wr_mask(input int k);
        case (k)
            0:       return 8'hFF;
            1:       return 8'h0F;
            2:       return 8'h7F;
            3:       return 8'hFF;
            4:       return 8'h0F;
            default: return 8'h13;
        endcase
    endfunction

    function automatic logic [7:0] ones_mask(input int k);
        case (k)
            1:       return 8'h70;
            4:       return 8'h70;
            5:       return 8'h6C;
            default: return 8'h00;
        endcase
    endfunction

endpackage

// File: rtl/bus_line_sync.sv
module bus_line_sync #(
    parameter int WIDTH  = 2,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] dout,
    output logic [WIDTH-1:0] dprev
);
    logic [STAGES:0][WIDTH-1:0] chain_q;
    logic [STAGES:0][WIDTH-1:0] chain_d;

    always_comb begin
        chain_d[0] = din;
        for (int s = 1; s <= STAGES; s++) begin
            chain_d[s] = chain_q[s-1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= '1;
        else        chain_q <= chain_d;
    end

    assign dout  = chain_q[STAGES-1];
    assign dprev = chain_q[STAGES];
endmodule

// File: rtl/cfg_store.sv
module cfg_store
    import clkcfg_pkg::*;
#(
    parameter logic VERSION = 1'b0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [IDXW-1:0]   wr_idx,
    input  logic [7:0]        wr_data,
    input  logic [2:0]        strap_fs,
    output logic [NREG*8-1:0] image_o
);
    logic [NREG-1:0][7:0] store_q;
    logic [NREG-1:0][7:0] store_d;

    always_comb begin
        store_d = store_q;
        for (int k = 0; k < NREG; k++) begin
            if (wr_en && wr_idx == IDXW'(k)) store_d[k] = wr_data & wr_mask(k);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int k = 0; k < NREG; k++) store_q[k] <= (k == 0) ? 8'h00 : wr_mask(k);
        end else begin
            store_q <= store_d;
        end
    end

    genvar g;
    generate
        for (g = 0; g < NREG; g++) begin : g_img
            logic [7:0] base;
            assign base = (store_q[g] & wr_mask(g)) | ones_mask(g);
            if (g == 1) begin : g_ver
                assign image_o[8*g +: 8] = {VERSION, base[6:0]};
            end else if (g == 2) begin : g_fs1
                assign image_o[8*g +: 8] = {~strap_fs[1], base[6:0]};
            end else if (g == 4) begin : g_fs0
                assign image_o[8*g +: 8] = {~strap_fs[0], base[6:0]};
            end else if (g == 5) begin : g_fs2
                assign image_o[8*g +: 8] = {~strap_fs[2], base[6:0]};
            end else begin : g_plain
                assign image_o[8*g +: 8] = base;
            end
        end
    endgenerate

    p_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(store_q));
    p_idx_range_r3: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> wr_idx < IDXW'(NREG));
endmodule

// File: rtl/blk_bus_engine.sv
module blk_bus_engine
    import clkcfg_pkg::*;
#(
    parameter logic [7:0] WR_ADDR = 8'hD2,
    parameter logic [7:0] RD_ADDR = 8'hD3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scl_s,
    input  logic              scl_p,
    input  logic              sda_s,
    input  logic              sda_p,
    input  logic [NREG*8-1:0] image_i,
    output logic              sda_oe,
    output logic              wr_en,
    output logic [IDXW-1:0]   wr_idx,
    output logic [7:0]        wr_data
);
    localparam logic [IDXW-1:0] FIRST_DATA = IDXW'(2);
    localparam logic [IDXW-1:0] END_DATA   = IDXW'(2 + NREG);
    localparam logic [IDXW-1:0] IDX_MAX    = '1;

    eng_t q, d;
    logic rise, fall, start_c, stop_c;
    logic [7:0] byte_in, tx_byte;

    assign rise    = scl_s & ~scl_p;
    assign fall    = ~scl_s & scl_p;
    assign start_c = scl_s & scl_p & sda_p & ~sda_s;
    assign stop_c  = scl_s & scl_p & ~sda_p & sda_s;
    assign byte_in = {q.sh[6:0], sda_s};

    always_comb begin
        tx_byte = 8'hFF;
        if (q.idx == '0) tx_byte = 8'(NREG);
        for (int k = 0; k < NREG; k++) begin
            if (q.idx == IDXW'(k + 1)) tx_byte = image_i[8*k +: 8];
        end
    end

    always_comb begin
        d       = q;
        wr_en   = 1'b0;
        wr_data = byte_in;
        if (start_c) begin
            d.state   = S_RX;
            d.cnt     = '0;
            d.addr_ph = 1'b1;
            d.rd      = 1'b0;
            d.oe      = 1'b0;
        end else if (stop_c) begin
            d.state = S_IDLE;
            d.oe    = 1'b0;
        end else begin
            case (q.state)
                S_RX: if (rise) begin
                    d.sh = byte_in;
                    if (q.cnt == CNTW'(7)) begin
                        d.cnt = '0;
                        if (q.addr_ph) begin
                            d.addr_ph = 1'b0;
                            d.idx     = '0;
                            if (byte_in == WR_ADDR) begin
                                d.rd    = 1'b0;
                                d.state = S_ACK1;
                            end else if (byte_in == RD_ADDR) begin
                                d.rd    = 1'b1;
                                d.state = S_ACK1;
                            end else begin
                                d.state = S_IDLE;
                            end
                        end else begin
                            wr_en   = (q.idx >= FIRST_DATA) && (q.idx < END_DATA);
                            d.state = S_ACK1;
                            if (q.idx != IDX_MAX) d.idx = q.idx + 1'b1;
                        end
                    end else begin
                        d.cnt = q.cnt + 1'b1;
                    end
                end
                S_ACK1: if (fall) begin
                    d.oe    = 1'b1;
                    d.state = S_ACK2;
                end
                S_ACK2: if (fall) begin
                    d.cnt = '0;
                    if (q.rd) begin
                        d.sh    = tx_byte;
                        d.oe    = ~tx_byte[7];
                        d.state = S_TX;
                        if (q.idx != IDX_MAX) d.idx = q.idx + 1'b1;
                    end else begin
                        d.oe    = 1'b0;
                        d.state = S_RX;
                    end
                end
                S_TX: begin
                    if (rise) d.cnt = q.cnt + 1'b1;
                    if (fall) begin
                        if (q.cnt == CNTW'(8)) begin
                            d.oe    = 1'b0;
                            d.state = S_TXACK;
                        end else begin
                            d.sh = {q.sh[6:0], 1'b1};
                            d.oe = ~q.sh[6];
                        end
                    end
                end
                S_TXACK: begin
                    if (rise) d.mack = ~sda_s;
                    if (fall) begin
                        d.cnt = '0;
                        if (q.mack) begin
                            d.sh    = tx_byte;
                            d.oe    = ~tx_byte[7];
                            d.state = S_TX;
                            if (q.idx != IDX_MAX) d.idx = q.idx + 1'b1;
                        end else begin
                            d.oe    = 1'b0;
                            d.state = S_IDLE;
                        end
                    end
                end
                default: d.oe = 1'b0;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q         <= '0;
            q.state   <= S_IDLE;
        end else begin
            q <= d;
        end
    end

    assign sda_oe = q.oe;
    assign wr_idx = q.idx - FIRST_DATA;

    p_ack_slot_r1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(q.oe) |-> (q.state == S_ACK2 || q.state == S_TX));
    p_start_rearm_r4: assert property (@(posedge clk) disable iff (!rst_n)
        start_c |=> (q.state == S_RX && q.cnt == '0 && q.addr_ph));
    p_stop_release_r9: assert property (@(posedge clk) disable iff (!rst_n)
        stop_c |=> !q.oe);
    p_idle_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
        q.state == S_IDLE |-> !q.oe);
    p_wr_then_ack_r2: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> q.state == S_ACK1);
endmodule

// File: rtl/clkcfg_serial_slave.sv
module clkcfg_serial_slave
    import clkcfg_pkg::*;
#(
    parameter logic [7:0] WR_ADDR = 8'hD2,
    parameter logic [7:0] RD_ADDR = 8'hD3,
    parameter logic       VERSION = 1'b0,
    parameter int         SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scl_i,
    input  logic              sda_i,
    input  logic [2:0]        strap_fs,
    output logic              sda_oe,
    output logic [NREG*8-1:0] cfg_o
);
    logic [1:0]      line_s, line_p;
    logic            wr_en;
    logic [IDXW-1:0] wr_idx;
    logic [7:0]      wr_data;

    bus_line_sync #(.WIDTH(2), .STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .din   ({scl_i, sda_i}),
        .dout  (line_s),
        .dprev (line_p)
    );

    blk_bus_engine #(.WR_ADDR(WR_ADDR), .RD_ADDR(RD_ADDR)) u_eng (
        .clk     (clk),
        .rst_n   (rst_n),
        .scl_s   (line_s[1]),
        .scl_p   (line_p[1]),
        .sda_s   (line_s[0]),
        .sda_p   (line_p[0]),
        .image_i (cfg_o),
        .sda_oe  (sda_oe),
        .wr_en   (wr_en),
        .wr_idx  (wr_idx),
        .wr_data (wr_data)
    );

    cfg_store #(.VERSION(VERSION)) u_store (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_en),
        .wr_idx   (wr_idx),
        .wr_data  (wr_data),
        .strap_fs (strap_fs),
        .image_o  (cfg_o)
    );
endmodule

// File: tb/tb_clkcfg_serial_slave.sv
module tb_clkcfg_serial_slave;
    localparam int Q = 40;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        scl = 1'b1;
    logic        m_sda = 1'b1;
    logic [2:0]  strap = 3'b101;
    logic        sda_oe;
    logic [47:0] cfg_o;
    wire         sda_bus = m_sda & ~sda_oe;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;
    logic [7:0] model [6];

    always #2.5 clk = ~clk;

    clkcfg_serial_slave dut (
        .clk(clk), .rst_n(rst_n), .scl_i(scl), .sda_i(sda_bus),
        .strap_fs(strap), .sda_oe(sda_oe), .cfg_o(cfg_o)
    );

    // {byte count, bytes 5..0}
    localparam logic [55:0] ROWS [4] = '{
        {8'd6, 48'h000000000000},
        {8'd6, 48'hFFFFFFFFFFFF},
        {8'd6, 48'h69963CC35AA5},
        {8'd2, 48'h000000003412}
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    function automatic logic [7:0] exp_byte(input int k);
        logic [7:0] wm, om, b;
        case (k)
            0: begin wm = 8'hFF; om = 8'h00; end
            1: begin wm = 8'h0F; om = 8'h70; end
            2: begin wm = 8'h7F; om = 8'h00; end
            3: begin wm = 8'hFF; om = 8'h00; end
            4: begin wm = 8'h0F; om = 8'h70; end
            default: begin wm = 8'h13; om = 8'h6C; end
        endcase
        b = (model[k] & wm) | om;
        if (k == 2) b[7] = ~strap[1];
        if (k == 4) b[7] = ~strap[0];
        if (k == 5) b[7] = ~strap[2];
        return b;
    endfunction

    task automatic bit_cyc(input logic v, output logic s);
        m_sda = v;
        #(Q); scl = 1'b1;
        #(Q); s = sda_bus;
        #(Q); scl = 1'b0;
        #(Q);
    endtask

    task automatic bus_start();
        m_sda = 1'b1; #(Q);
        scl = 1'b1;   #(Q);
        m_sda = 1'b0; #(Q);
        scl = 1'b0;   #(Q);
    endtask

    task automatic bus_stop();
        m_sda = 1'b0; #(Q);
        scl = 1'b1;   #(Q);
        m_sda = 1'b1; #(Q);
    endtask

    task automatic send_byte(input logic [7:0] b, output logic acked);
        logic s;
        for (int i = 7; i >= 0; i--) bit_cyc(b[i], s);
        bit_cyc(1'b1, s);
        acked = ~s;
    endtask

    task automatic recv_byte(input logic ack, output logic [7:0] b);
        logic s;
        for (int i = 7; i >= 0; i--) begin
            bit_cyc(1'b1, s);
            b[i] = s;
        end
        bit_cyc(~ack, s);
    endtask

    task automatic block_write(input logic [47:0] data, input int n, input string req);
        logic a;
        bus_start();
        send_byte(8'hD2, a);  check({req, " R1 write address ack"}, a, 1);
        send_byte(8'hAA, a);  check({req, " R2 command ack"}, a, 1);
        send_byte(8'h55, a);  check({req, " R2 count ack"}, a, 1);
        for (int k = 0; k < n; k++) begin
            send_byte(data[8*k +: 8], a);
            check({req, " R2 data ack"}, a, 1);
            model[k] = data[8*k +: 8];
        end
        bus_stop();
    endtask

    task automatic block_read(input string req);
        logic a;
        logic [7:0] b;
        bus_start();
        send_byte(8'hD3, a);  check({req, " R1 read address ack"}, a, 1);
        recv_byte(1'b1, b);   check({req, " R5 count"}, b, 6);
        for (int k = 0; k < 6; k++) begin
            recv_byte(k != 5, b);
            check({req, " R5 read byte"}, b, exp_byte(k));
        end
        bus_stop();
        #(Q);
        check({req, " R9 released after stop"}, sda_oe, 0);
    endtask

    task automatic check_image(input string req);
        #(Q);
        for (int k = 0; k < 6; k++) check({req, " R8 cfg_o byte"}, cfg_o[8*k +: 8], exp_byte(k));
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        logic a, s;
        logic [7:0] b;
        model[0] = 8'h00;
        for (int k = 1; k < 6; k++) model[k] = 8'hFF;
        repeat (5) @(posedge clk);
        #1 rst_n = 1'b1;
        #(Q);

        // R6 / R7: reset image
        check("R6 byte0 default", cfg_o[7:0], 8'h00);
        check_image("R6 R7 reset");
        block_read("R6 reset readback");

        // table of block writes, each followed by a block read
        for (int r = 0; r < 4; r++) begin
            block_write(ROWS[r][47:0], int'(ROWS[r][55:48]), "table");
            check_image("R2 R3 table");
            block_read("table readback");
        end

        // R1: foreign address not acknowledged, image untouched
        bus_start();
        send_byte(8'hA0, a);
        check("R1 foreign address nack", a, 0);
        send_byte(8'h00, a);
        check("R1 silent after foreign address", a, 0);
        bus_stop();
        check_image("R1 foreign");

        // R3: overrun past byte 5
        bus_start();
        send_byte(8'hD2, a); send_byte(8'h01, a); send_byte(8'h02, a);
        for (int k = 0; k < 6; k++) begin
            send_byte(8'h10 + 8'(k), a);
            model[k] = 8'h10 + 8'(k);
        end
        send_byte(8'hEE, a); check("R3 byte 6 acked", a, 1);
        send_byte(8'hDD, a); check("R3 byte 7 acked", a, 1);
        bus_stop();
        check_image("R3 overrun");

        // R4: STOP in mid-byte
        bus_start();
        send_byte(8'hD2, a); send_byte(8'h00, a); send_byte(8'h00, a);
        send_byte(8'h3C, a); model[0] = 8'h3C;
        for (int i = 0; i < 4; i++) bit_cyc(1'b0, s);
        bus_stop();
        check_image("R4 stop mid-byte");

        // R4: repeated START in mid-byte, then a read
        bus_start();
        send_byte(8'hD2, a); send_byte(8'h00, a); send_byte(8'h00, a);
        for (int i = 0; i < 3; i++) bit_cyc(1'b1, s);
        bus_start();
        send_byte(8'hD3, a);
        check("R4 restart address ack", a, 1);
        recv_byte(1'b1, b); check("R4 count after restart", b, 6);
        recv_byte(1'b0, b); check("R4 byte0 kept", b, 8'h3C);
        bus_stop();

        // R7: strap change and write to read-only bits
        strap = 3'b010;
        block_write(48'hFFFFFFFFFFFF, 6, "R7 ro");
        check("R7 byte1 version bit", cfg_o[15], 1'b0);
        check("R7 byte4 strap bit", cfg_o[39], 1'b1);
        check_image("R7 strap");

        // R9: early master NACK
        bus_start();
        send_byte(8'hD3, a);
        recv_byte(1'b0, b); check("R9 count", b, 6);
        #(Q);
        check("R9 released after nack", sda_oe, 0);
        bus_stop();
        block_read("R9 after nack");

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule